// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits next to the receive side of an asynchronous UART and decides, once per completed frame, whether that frame should raise the receive flag. It does not handle individual serial bits. The receiver hands it the eight data bits, the ninth bit, a stop-bit validity indication and a one-cycle frame-done strobe. The block answers with a one-cycle receive-flag set pulse. It also keeps a sticky framing-error flag.

Two configuration bytes are written over a simple register-write port: an own-address byte and an address mask byte. A mask bit of 0 makes the corresponding address bit a don't-care. The filter is active only when multiprocessor filtering is enabled and the UART runs one of its two 9-bit modes. In that case only frames whose ninth bit is 1 are treated as address frames, and each one is compared two ways:
- against the unit's individual address, ignoring bits whose mask bit is 0;
- against a shared broadcast address built as address OR mask. Bits that are 0 in both are don't-cares.

A secondary station uses this to ignore data traffic meant for other stations.

Top module: `uart_addr_filter`

## Requirements
- R1: After reset the address and mask bytes are both 00h, `rx_flag_set` and `frame_err` are 0, and any address frame (ninth bit 1) is accepted while filtering is active.
- R2: `uart_mode` encodes 2'b00 shift register, 2'b01 8-bit UART, 2'b10 9-bit fixed rate, 2'b11 9-bit variable rate. In modes 2'b00 and 2'b01, or whenever `mp_enable` is 0, every frame-done strobe produces a receive-flag pulse.
- R3: With `mp_enable` 1 in mode 2'b10 or 2'b11, a frame whose ninth bit is 0 never produces a pulse.
- R4: With filtering active and ninth bit 1, a frame whose data equals the address in every bit where the mask is 1 produces a pulse (individual match).
- R5: With filtering active and ninth bit 1, a frame whose data has a 1 in every bit that is 1 in (address OR mask) produces a pulse (broadcast match).
- R6: With filtering active and ninth bit 1, a frame matching neither the individual nor the broadcast pattern produces no pulse.
- R7: With mask FFh, only the exact address and the broadcast value FFh are accepted.
- R8: In modes 2'b01, 2'b10 and 2'b11, a frame-done strobe with `stop_ok` 0 sets `frame_err` in the next cycle. In mode 2'b00 the stop indication is ignored.
- R9: `frame_err` stays set until `ferr_clear` is pulsed. A new framing error in the same cycle as the clear leaves it set.
- R10: `cfg_wr` with `cfg_sel` 0 loads the address byte and with `cfg_sel` 1 loads the mask byte. Each write affects only its own byte and applies to frames completing in later cycles.
- R11: `rx_flag_set` is high for exactly the one cycle after an accepted frame-done strobe, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 address byte, 1 mask byte |
| cfg_wdata | input | 8 | Configuration write data |
| uart_mode | input | 2 | UART operating mode |
| mp_enable | input | 1 | Multiprocessor filtering enable |
| frame_done | input | 1 | One-cycle strobe: a frame has been received |
| rx_byte | input | 8 | Received data bits |
| rx_bit9 | input | 1 | Received ninth bit |
| stop_ok | input | 1 | Received stop bit was valid |
| ferr_clear | input | 1 | Clears the framing-error flag |
| rx_flag_set | output | 1 | One-cycle receive-flag set pulse |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Some properties are checked on every cycle:
- the pulse appears only in the cycle after a strobe;
- non-address frames are always rejected while filtering is active;
- the flag is forced through when filtering is off;
- the framing-error flag sets and holds;
- register writes land in the selected byte;
- a full mask reduces the individual comparison to equality.

Other behaviour only shows in the bench's scenarios: whether particular address, mask and data combinations are accepted, for example the don't-care bits and the broadcast pattern against concrete values. The same goes for the all-match state after reset and the precedence between a framing-error clear and a new error in the same cycle.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_8BIT   = 2'b01,
    MODE_9FIXED = 2'b10,
    MODE_9VAR   = 2'b11
  } uart_mode_e;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/afr_rst_sync.sv
module afr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/afr_regs.sv
module afr_regs
  import afr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] own_addr,
  output logic [DW-1:0] addr_mask
);
  logic [DW-1:0] addr_q, addr_d;
  logic [DW-1:0] mask_q, mask_d;
  logic          addr_en, mask_en;

  always_comb begin
    addr_en = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_ADDR);
    mask_en = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_MASK);
    addr_d  = addr_en ? cfg_wdata : addr_q;
    mask_d  = mask_en ? cfg_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else begin
      addr_q <= addr_d;
      mask_q <= mask_d;
    end
  end

  assign own_addr  = addr_q;
  assign addr_mask = mask_q;

  // R10: a write lands in the selected byte and leaves the other untouched
  assert_addr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_sel) |=> (own_addr == $past(cfg_wdata) && $stable(addr_mask)));
  assert_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel) |=> (addr_mask == $past(cfg_wdata) && $stable(own_addr)));
endmodule

// File: rtl/afr_match.sv
module afr_match #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic [DW-1:0] rx_byte,
  output logic          hit_given,
  output logic          hit_bcast
);
  logic [DW-1:0] given_bit;
  logic [DW-1:0] bcast_bit;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      // bit is don't-care when its mask bit is clear
      given_bit[i] = !addr_mask[i] || (rx_byte[i] == own_addr[i]);
      // broadcast pattern bit is address OR mask; zero in both is don't-care
      bcast_bit[i] = !(own_addr[i] || addr_mask[i]) || rx_byte[i];
    end
  end

  assign hit_given = &given_bit;
  assign hit_bcast = &bcast_bit;

  // R7: with a full mask the individual comparison is plain equality
  assert_fullmask_eq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_mask == {DW{1'b1}}) |-> (hit_given == (rx_byte == own_addr)));
  // R1: an all-zero address and mask accept every byte on both paths
  assert_zero_cfg_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (own_addr == '0 && addr_mask == '0) |-> (hit_given && hit_bcast));
endmodule

// File: rtl/afr_qual.sv
module afr_qual
  import afr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] uart_mode,
  input  logic       mp_enable,
  input  logic       frame_done,
  input  logic       rx_bit9,
  input  logic       stop_ok,
  input  logic       ferr_clear,
  input  logic       hit_given,
  input  logic       hit_bcast,
  output logic       rx_flag_set,
  output logic       frame_err
);
  logic filter_on, accept, fe_hit;
  logic set_q, set_d;
  logic ferr_q, ferr_d;

  always_comb begin
    filter_on = mp_enable && ((uart_mode_e'(uart_mode) == MODE_9FIXED) ||
                              (uart_mode_e'(uart_mode) == MODE_9VAR));
    accept    = !filter_on || (rx_bit9 && (hit_given || hit_bcast));
    set_d     = frame_done && accept;
    fe_hit    = frame_done && (uart_mode_e'(uart_mode) != MODE_SHIFT) && !stop_ok;
    if (fe_hit)          ferr_d = 1'b1;
    else if (ferr_clear) ferr_d = 1'b0;
    else                 ferr_d = ferr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      set_q  <= set_d;
      ferr_q <= ferr_d;
    end
  end

  assign rx_flag_set = set_q;
  assign frame_err   = ferr_q;

  // R11: a pulse only follows a frame-done strobe
  assert_pulse_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag_set |-> $past(frame_done));
  // R3: non-address frames are dropped while filtering
  assert_drop_data_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && mp_enable && uart_mode[1] && !rx_bit9) |=> !rx_flag_set);
  // R2: no filtering means every frame is flagged
  assert_pass_unfiltered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !(mp_enable && uart_mode[1])) |=> rx_flag_set);
  // R8: bad stop bit outside shift mode raises the error flag
  assert_ferr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && uart_mode != 2'b00 && !stop_ok) |=> frame_err);
  // R8: shift-mode frames never raise the error flag
  assert_ferr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_err && !(frame_done && uart_mode != 2'b00 && !stop_ok)) |=> !frame_err);
  // R9: the error flag holds until cleared
  assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err && !ferr_clear) |=> frame_err);
endmodule

// File: rtl/uart_addr_filter.sv
module uart_addr_filter #(
  parameter int DW = 8,
  parameter int RST_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [1:0]    uart_mode,
  input  logic          mp_enable,
  input  logic          frame_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_bit9,
  input  logic          stop_ok,
  input  logic          ferr_clear,
  output logic          rx_flag_set,
  output logic          frame_err
);
  logic          rst_n_int;
  logic [DW-1:0] own_addr, addr_mask;
  logic          hit_given, hit_bcast;

  afr_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  afr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .own_addr(own_addr), .addr_mask(addr_mask)
  );

  afr_match #(.DW(DW)) u_match (
    .clk(clk), .rst_n(rst_n_int), .own_addr(own_addr), .addr_mask(addr_mask),
    .rx_byte(rx_byte), .hit_given(hit_given), .hit_bcast(hit_bcast)
  );

  afr_qual u_qual (
    .clk(clk), .rst_n(rst_n_int), .uart_mode(uart_mode), .mp_enable(mp_enable),
    .frame_done(frame_done), .rx_bit9(rx_bit9), .stop_ok(stop_ok),
    .ferr_clear(ferr_clear), .hit_given(hit_given), .hit_bcast(hit_bcast),
    .rx_flag_set(rx_flag_set), .frame_err(frame_err)
  );
endmodule

// File: tb/uart_addr_filter_bench.sv
module uart_addr_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] uart_mode = 2'b10;
  logic       mp_enable = 1'b0, frame_done = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_bit9 = 1'b0, stop_ok = 1'b1, ferr_clear = 1'b0;
  logic       rx_flag_set, frame_err;
  int         n_run = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  uart_addr_filter u_uart_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .uart_mode(uart_mode), .mp_enable(mp_enable),
    .frame_done(frame_done), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .stop_ok(stop_ok), .ferr_clear(ferr_clear),
    .rx_flag_set(rx_flag_set), .frame_err(frame_err)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       mp;
    logic [7:0] addr;
    logic [7:0] mask;
    logic [7:0] data;
    logic       b9;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  // R2 pass-through, R3 data frames, R4 individual, R5 broadcast, R6 miss, R7 full mask
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 1'b1, 8'h56, 8'hFC, 8'h54, 1'b1, 1'b1, 4'd4},
    '{2'b10, 1'b1, 8'h56, 8'hFC, 8'h57, 1'b1, 1'b1, 4'd4},
    '{2'b10, 1'b1, 8'h56, 8'hFC, 8'h46, 1'b1, 1'b0, 4'd6},
    '{2'b10, 1'b1, 8'h56, 8'hFC, 8'hFE, 1'b1, 1'b1, 4'd5},
    '{2'b11, 1'b1, 8'h56, 8'hFC, 8'hFF, 1'b1, 1'b1, 4'd5},
    '{2'b11, 1'b1, 8'h56, 8'hFC, 8'h56, 1'b0, 1'b0, 4'd3},
    '{2'b11, 1'b0, 8'h56, 8'hFC, 8'h00, 1'b0, 1'b1, 4'd2},
    '{2'b01, 1'b1, 8'h56, 8'hFC, 8'h00, 1'b0, 1'b1, 4'd2},
    '{2'b00, 1'b1, 8'h56, 8'hFC, 8'h12, 1'b0, 1'b1, 4'd2},
    '{2'b10, 1'b1, 8'hF1, 8'hFA, 8'hF1, 1'b1, 1'b1, 4'd4},
    '{2'b10, 1'b1, 8'hF1, 8'hFA, 8'hF5, 1'b1, 1'b1, 4'd4},
    '{2'b10, 1'b1, 8'hF1, 8'hFA, 8'hF3, 1'b1, 1'b0, 4'd6},
    '{2'b10, 1'b1, 8'hF1, 8'hFA, 8'hFB, 1'b1, 1'b1, 4'd5},
    '{2'b11, 1'b1, 8'h33, 8'hFF, 8'h33, 1'b1, 1'b1, 4'd7},
    '{2'b11, 1'b1, 8'h33, 8'hFF, 8'h32, 1'b1, 1'b0, 4'd7},
    '{2'b11, 1'b1, 8'h33, 8'hFF, 8'hFF, 1'b1, 1'b1, 4'd7},
    '{2'b10, 1'b1, 8'h00, 8'h00, 8'h9A, 1'b1, 1'b1, 4'd1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic sel, input logic [7:0] val);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // drive one strobe; on return the registered pulse is visible
  task automatic frame(input logic [7:0] d, input logic b9, input logic stop);
    rx_byte = d; rx_bit9 = b9; stop_ok = stop; frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0; stop_ok = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 flag after reset", rx_flag_set, 1'b0);
    check("R1 ferr after reset", frame_err, 1'b0);
    uart_mode = 2'b10; mp_enable = 1'b1;
    frame(8'hA5, 1'b1, 1'b1);
    check("R1 all-match after reset", rx_flag_set, 1'b1);
    @(negedge clk);
    // R11: pulse lasts a single cycle
    check("R11 pulse ends", rx_flag_set, 1'b0);

    for (int i = 0; i < NV; i++) begin
      write_cfg(1'b0, VECS[i].addr);
      write_cfg(1'b1, VECS[i].mask);
      uart_mode = VECS[i].mode; mp_enable = VECS[i].mp;
      frame(VECS[i].data, VECS[i].b9, 1'b1);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), rx_flag_set, VECS[i].exp);
    end

    // R10: mask write does not touch the address byte
    write_cfg(1'b0, 8'h10);
    write_cfg(1'b1, 8'hFF);
    uart_mode = 2'b10; mp_enable = 1'b1;
    frame(8'h1A, 1'b1, 1'b1);
    check("R10 full mask rejects 1A", rx_flag_set, 1'b0);
    write_cfg(1'b1, 8'hF0);
    frame(8'h1A, 1'b1, 1'b1);
    check("R10 new mask accepts 1A", rx_flag_set, 1'b1);

    // R8: mode 0 ignores stop, other modes flag it
    uart_mode = 2'b00;
    frame(8'h00, 1'b0, 1'b0);
    check("R8 shift mode no ferr", frame_err, 1'b0);
    uart_mode = 2'b01;
    frame(8'h00, 1'b0, 1'b0);
    check("R8 ferr set", frame_err, 1'b1);
    // R9: sticky, clear, and set beats clear
    repeat (3) @(negedge clk);
    check("R9 ferr sticky", frame_err, 1'b1);
    ferr_clear = 1'b1;
    @(negedge clk);
    ferr_clear = 1'b0;
    check("R9 ferr cleared", frame_err, 1'b0);
    ferr_clear = 1'b1;
    frame(8'h00, 1'b0, 1'b0);
    ferr_clear = 1'b0;
    check("R9 set wins over clear", frame_err, 1'b1);

    // R11: no pulse without a strobe
    repeat (2) @(negedge clk);
    check("R11 idle no pulse", rx_flag_set, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule